// File: doc/BRIEF.md
# Paged Digital I/O Controller with Edge Interrupts

This block exposes 48 digital lines as six byte-wide ports behind a small host register bus with a 4-bit address. It has separate read and write strobes and data buses in each direction. Every port has an output latch that the host writes. A read of a port returns the line levels after a two-stage synchroniser. A host can make any port read-only by setting that port's lock bit. Once locked, output writes to the port are dropped, but reads still return the line levels.

The first three ports can raise interrupts. Each line of these ports has an edge detector with a programmable direction and an enable bit. A detected edge sets a sticky identification bit for that line. A bank register selects one of four banks. The selected bank decides what the three addresses after the bank register reach:

- bank 0: nothing.
- bank 1: direction registers.
- bank 2: enable registers.
- bank 3: identification registers.

A summary register shows which interrupt-capable ports hold any latched edge. A single interrupt output is asserted while any of them does. Software services an interrupt in four steps:

1. Read the summary register.
2. Switch to bank 3.
3. Read the identification register of each flagged port.
4. Write zero to that register to clear it.

Top module: `paged_dio_irq`

## Requirements
- R1: Addresses 0 to 5 reach ports 0 to 5. A write loads that port's output byte. A read returns the port's line levels through a two-flop synchroniser.
- R2: Address 7 is a write-only bank register. Bits 7:6 select bank 0 to 3. Bit k (k = 0 to 5) locks port k. A read of address 7 returns 0x00.
- R3: A write to a locked port leaves its output byte unchanged. A read of a locked port still returns its line levels, and unlocked ports stay writable.
- R4: Address 6 reads the summary register. Bit i (i = 0 to 2) is 1 when any identification bit of port i is set, and bits 7:3 read 0.
- R5: On bank 0, addresses 8 to 10 read 0x00, and writes to them change no state.
- R6: On bank 1, addresses 8 to 10 are write-only direction registers for ports 0 to 2, and they read 0x00. A direction bit of 1 selects a rising edge and 0 selects a falling edge. A qualifying edge on a line appears in its identification bit three clock edges after the line changes.
- R7: On bank 2, addresses 8 to 10 are write-only per-line enables for ports 0 to 2, and they read 0x00. An edge on a line whose enable is 0 never sets its identification bit.
- R8: On bank 3, addresses 8 to 10 read the identification registers of ports 0 to 2. A write clears every identification bit whose data bit is 0, so writing 0x00 clears all of them. An edge that arrives in the same cycle as the write still sets its bit.
- R9: Ports 3 to 5 never set any identification bit or the interrupt output.
- R10: The interrupt output `irq` is high exactly when any summary bit is 1.
- R11: Reset (synchronous, active high) clears these:
  - all output bytes
  - directions, enables and identification bits
  - lock bits
  - the bank select, leaving bank 0 active

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when `bus_rd` is low |
| line_in | input | 48 | Line levels, port k on bits 8k+7:8k |
| line_out | output | 48 | Output latches, port k on bits 8k+7:8k |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a line that is still enabled but has its edge rejected. The edge goes the wrong way, or its enable bit is clear, while the neighbouring lines are armed. Reaching it needs a long bus sequence per case:

1. Disable the port.
2. Settle every line of the port at a baseline level.
3. Program the direction.
4. Arm a single line.
5. Clear the identification register.
6. Toggle the unarmed lines and confirm that nothing was latched.
7. Toggle the armed line.

The bench sweeps this sequence over every line of ports 0 to 2 in both directions. Separate sequences cover partial clears, several ports pending at once, and writes to the shared addresses on bank 0.

// File: rtl/paged_dio_pkg.sv
package paged_dio_pkg;
    localparam int PORT_W        = 8;
    localparam int NUM_PORTS     = 6;
    localparam int NUM_IRQ_PORTS = 3;
    localparam int ADDR_W        = 4;
    localparam int LINES         = PORT_W * NUM_PORTS;
    localparam int IDX_W         = $clog2(NUM_PORTS);

    localparam logic [ADDR_W-1:0] SUMMARY_ADDR = ADDR_W'(NUM_PORTS);
    localparam logic [ADDR_W-1:0] BANK_ADDR    = ADDR_W'(NUM_PORTS + 1);
    localparam logic [ADDR_W-1:0] SHARED_BASE  = ADDR_W'(NUM_PORTS + 2);
    localparam logic [ADDR_W-1:0] SHARED_END   = ADDR_W'(NUM_PORTS + 2 + NUM_IRQ_PORTS);

    typedef enum logic [1:0] {
        BANK_NONE  = 2'd0,
        BANK_DIR   = 2'd1,
        BANK_ENA   = 2'd2,
        BANK_IDENT = 2'd3
    } bank_e;

    // Layout of the bank register; its width matches one port byte.
    typedef struct packed {
        bank_e                 bank;
        logic [NUM_PORTS-1:0]  lock;
    } bank_reg_t;

    typedef enum logic [2:0] {
        TGT_PORT, TGT_SUMMARY, TGT_BANK, TGT_SHARED, TGT_NONE
    } target_e;

    typedef struct packed {
        target_e           tgt;
        logic [IDX_W-1:0]  idx;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.tgt = TGT_NONE;
        d.idx = '0;
        if (a < SUMMARY_ADDR) begin
            d.tgt = TGT_PORT;
            d.idx = IDX_W'(a);
        end else if (a == SUMMARY_ADDR) begin
            d.tgt = TGT_SUMMARY;
        end else if (a == BANK_ADDR) begin
            d.tgt = TGT_BANK;
        end else if (a >= SHARED_BASE && a < SHARED_END) begin
            d.tgt = TGT_SHARED;
            d.idx = IDX_W'(a - SHARED_BASE);
        end
        return d;
    endfunction
endpackage

// File: rtl/paged_dio_sync.sv
module paged_dio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
        end
    end

    assign synced = stage2;
endmodule

// File: rtl/paged_dio_edge_port.sv
module paged_dio_edge_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic         dir_we,
    input  logic         ena_we,
    input  logic         ident_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ident,
    output logic         any_set
);
    logic [W-1:0] prev_q, dir_q, ena_q, ident_q;
    logic [W-1:0] rise, fall, hit, kept;

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
    assign hit  = ena_q & ((dir_q & rise) | (~dir_q & fall));
    assign kept = ident_we ? (ident_q & wdata) : ident_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            dir_q   <= '0;
            ena_q   <= '0;
            ident_q <= '0;
        end else begin
            prev_q  <= level;
            ident_q <= kept | hit;
            if (dir_we) dir_q <= wdata;
            if (ena_we) ena_q <= wdata;
        end
    end

    assign ident   = ident_q;
    assign any_set = |ident_q;

    // R7: a bit may only become set if its enable was on the cycle before
    a_r7_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        ((ident_q & ~$past(ident_q) & ~$past(ena_q)) == '0));

    // R8: an all-zero clear with no coincident edge empties the register
    a_r8_zero_write_clears: assert property (@(posedge clk) disable iff (rst)
        (ident_we && wdata == '0 && hit == '0) |=> (ident_q == '0));
endmodule

// File: rtl/paged_dio_irq.sv
module paged_dio_irq
    import paged_dio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [PORT_W-1:0]  bus_wdata,
    output logic [PORT_W-1:0]  bus_rdata,
    input  logic [LINES-1:0]   line_in,
    output logic [LINES-1:0]   line_out,
    output logic               irq
);
    decode_t                                  dec;
    bank_reg_t                                bank_q;
    logic [NUM_PORTS-1:0][PORT_W-1:0]         out_q;
    logic [NUM_PORTS-1:0][PORT_W-1:0]         lvl;
    logic [LINES-1:0]                         lvl_flat;
    logic [NUM_IRQ_PORTS-1:0][PORT_W-1:0]     ident;
    logic [NUM_IRQ_PORTS-1:0]                 summary;

    assign dec = decode_addr(bus_addr);

    paged_dio_sync #(.W(LINES)) u_sync (
        .clk(clk), .rst(rst), .raw(line_in), .synced(lvl_flat)
    );
    assign lvl = lvl_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (bus_wr && dec.tgt == TGT_BANK) begin
            bank_q <= bank_reg_t'(bus_wdata);
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
        logic hit_p;
        assign hit_p = bus_wr && dec.tgt == TGT_PORT && dec.idx == IDX_W'(p);
        always_ff @(posedge clk) begin
            if (rst)                        out_q[p] <= '0;
            else if (hit_p && !bank_q.lock[p]) out_q[p] <= bus_wdata;
        end

        // R3: a locked port keeps its output byte across a write
        a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
            (hit_p && bank_q.lock[p]) |=> $stable(out_q[p]));
    end
    assign line_out = out_q;

    for (genvar i = 0; i < NUM_IRQ_PORTS; i++) begin : g_irq
        logic sel_i;
        assign sel_i = bus_wr && dec.tgt == TGT_SHARED && dec.idx == IDX_W'(i);
        paged_dio_edge_port #(.W(PORT_W)) u_edge (
            .clk      (clk),
            .rst      (rst),
            .level    (lvl[i]),
            .dir_we   (sel_i && bank_q.bank == BANK_DIR),
            .ena_we   (sel_i && bank_q.bank == BANK_ENA),
            .ident_we (sel_i && bank_q.bank == BANK_IDENT),
            .wdata    (bus_wdata),
            .ident    (ident[i]),
            .any_set  (summary[i])
        );
    end

    assign irq = |summary;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (dec.tgt)
                TGT_PORT:    bus_rdata = lvl[dec.idx];
                TGT_SUMMARY: bus_rdata = PORT_W'(summary);
                TGT_SHARED:  if (bank_q.bank == BANK_IDENT) bus_rdata = ident[dec.idx];
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R11: the first cycle after reset shows cleared outputs and no interrupt
    a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (line_out == '0 && irq == 1'b0));

    // R2: the bank register never drives read data
    a_r2_bank_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == BANK_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/test_paged_dio_irq.sv
module test_paged_dio_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] line_in = '0;
    logic [47:0] line_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [5:0] lock_sh = '0;

    always #5 clk = ~clk;

    paged_dio_irq i_paged_dio_irq (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_in(line_in), .line_out(line_out), .irq(irq)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic bank(input logic [1:0] b);
        wr(4'd7, {b, lock_sh});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        check("R11 outputs", line_out, 48'h0);
        check("R11 irq", {47'h0, irq}, 48'h0);
        rd(4'd6, v); check("R11 summary", {40'h0, v}, 48'h0);

        // R1: write and read every port
        for (int p = 0; p < 6; p++) begin
            wr(4'(p), 8'(8'h11 * (p + 1)));
            check("R1 write", {40'h0, line_out[p*8 +: 8]}, {40'h0, 8'(8'h11 * (p + 1))});
        end
        for (int p = 0; p < 6; p++) begin
            line_in[p*8 +: 8] = 8'(8'hA5 ^ (p * 8'h13));
        end
        settle();
        for (int p = 0; p < 6; p++) begin
            rd(4'(p), v);
            check("R1 read", {40'h0, v}, {40'h0, 8'(8'hA5 ^ (p * 8'h13))});
        end

        // R2/R3: lock each port in turn
        for (int p = 0; p < 6; p++) begin
            lock_sh = 6'(1 << p);
            bank(2'd0);
            rd(4'd7, v); check("R2 bank reads zero", {40'h0, v}, 48'h0);
            wr(4'(p), 8'h3C);
            check("R3 locked unchanged", {40'h0, line_out[p*8 +: 8]}, {40'h0, 8'(8'h11 * (p + 1))});
            rd(4'(p), v);
            check("R3 locked reads lines", {40'h0, v}, {40'h0, 8'(8'hA5 ^ (p * 8'h13))});
            wr(4'((p + 1) % 6), 8'h5A);
            check("R3 other writable", {40'h0, line_out[((p + 1) % 6)*8 +: 8]}, 48'h5A);
            wr(4'((p + 1) % 6), 8'(8'h11 * (((p + 1) % 6) + 1)));
        end
        lock_sh = '0;
        bank(2'd0);
        wr(4'd0, 8'hC3);
        check("R3 unlocked again", {40'h0, line_out[7:0]}, 48'hC3);

        // R5: bank 0 shared addresses do nothing
        line_in[23:0] = 24'h0;
        settle();
        for (int i = 0; i < 3; i++) begin
            wr(4'(8 + i), 8'hFF);
            rd(4'(8 + i), v); check("R5 bank0 reads zero", {40'h0, v}, 48'h0);
        end
        line_in[23:0] = 24'hFFFFFF; settle();
        line_in[23:0] = 24'h0; settle();
        bank(2'd3);
        for (int i = 0; i < 3; i++) begin
            rd(4'(8 + i), v); check("R5 no enable from bank0", {40'h0, v}, 48'h0);
        end

        // R6/R7/R8: sweep every line, both directions
        for (int p = 0; p < 3; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int b = 0; b < 8; b++) begin
                    bank(2'd2); wr(4'(8 + p), 8'h00);
                    line_in[p*8 +: 8] = (pol == 1) ? 8'h00 : 8'hFF;
                    settle();
                    bank(2'd1); wr(4'(8 + p), (pol == 1) ? 8'hFF : 8'h00);
                    rd(4'(8 + p), v); check("R6 dir reads zero", {40'h0, v}, 48'h0);
                    bank(2'd2); wr(4'(8 + p), 8'(1 << b));
                    rd(4'(8 + p), v); check("R7 ena reads zero", {40'h0, v}, 48'h0);
                    bank(2'd3); wr(4'(8 + p), 8'h00);
                    line_in[p*8 +: 8] = line_in[p*8 +: 8] ^ ~8'(1 << b);
                    settle();
                    rd(4'(8 + p), v); check("R7 disabled lines ignored", {40'h0, v}, 48'h0);
                    line_in[p*8 + b] = ~line_in[p*8 + b];
                    settle();
                    rd(4'(8 + p), v); check("R6 edge latched", {40'h0, v}, {40'h0, 8'(1 << b)});
                    check("R10 irq high", {47'h0, irq}, 48'h1);
                    rd(4'd6, v); check("R4 summary", {40'h0, v}, {40'h0, 8'(1 << p)});
                    line_in[p*8 + b] = ~line_in[p*8 + b];
                    settle();
                    rd(4'(8 + p), v); check("R6 opposite edge ignored", {40'h0, v}, {40'h0, 8'(1 << b)});
                    wr(4'(8 + p), 8'h00);
                    rd(4'(8 + p), v); check("R8 cleared", {40'h0, v}, 48'h0);
                    check("R10 irq low", {47'h0, irq}, 48'h0);
                end
            end
        end

        // R9: ports 3..5 never interrupt
        bank(2'd2);
        for (int i = 0; i < 3; i++) wr(4'(8 + i), 8'hFF);
        bank(2'd1);
        for (int i = 0; i < 3; i++) wr(4'(8 + i), 8'hFF);
        line_in[23:0] = 24'h0; settle();
        bank(2'd3);
        for (int i = 0; i < 3; i++) wr(4'(8 + i), 8'h00);
        line_in[47:24] = 24'h0; settle();
        line_in[47:24] = 24'hFFFFFF; settle();
        line_in[47:24] = 24'h0; settle();
        check("R9 irq stays low", {47'h0, irq}, 48'h0);
        rd(4'd6, v); check("R9 summary zero", {40'h0, v}, 48'h0);

        // R4/R8/R10: two ports pending, partial clear
        line_in[7:0] = 8'hFF; line_in[23:16] = 8'hFF; settle();
        rd(4'd6, v); check("R4 two pending", {40'h0, v}, 48'h05);
        rd(4'd8, v); check("R6 whole byte", {40'h0, v}, 48'hFF);
        wr(4'd8, 8'h0F);
        rd(4'd8, v); check("R8 partial clear", {40'h0, v}, 48'h0F);
        rd(4'd6, v); check("R4 still two", {40'h0, v}, 48'h05);
        wr(4'd8, 8'h00);
        rd(4'd6, v); check("R4 one left", {40'h0, v}, 48'h04);
        check("R10 irq with one", {47'h0, irq}, 48'h1);
        wr(4'd10, 8'h00);
        rd(4'd6, v); check("R4 none", {40'h0, v}, 48'h0);
        check("R10 irq cleared", {47'h0, irq}, 48'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule